// File: doc/BRIEF.md
# PLL Digital Lock Detect Filter

This block turns the reference and feedback edges seen by the phase detectors of several PLLs into a single, filtered lock indication. A fast sampling clock runs the block. For each PLL it watches for the rising edges of both pulse trains and counts the clock edges from the first edge of a comparison to the second. That count is the phase error of the comparison, in samples. The count sets whether the PLL is pumping up or down.

Each PLL has a hysteresis filter. Lock is declared only after a run of consecutive comparisons whose error is under a tight entry limit. Once locked, a wider exit limit applies, and a single comparison beyond it drops lock at once. The per-PLL verdicts are ANDed into one output. A PLL that is powered down or not active does not hold that output low. A mode input turns the output into an activity flag instead: it goes low whenever an included PLL is pumping.

Top module: `pll_lock_filter`

## Requirements
- R1: A PLL is declared locked once LOCK_CYCLES (default 5) comparisons in a row have an error below ENTRY_TH (default 4) samples. After only LOCK_CYCLES-1 such comparisons it is still unlocked.
- R2: While a PLL is unlocked, any comparison with an error of ENTRY_TH samples or more clears its run of good comparisons to zero.
- R3: While a PLL is locked, a comparison with an error of at most EXIT_TH (default 8) samples keeps the lock. A single comparison with an error above EXIT_TH drops the lock at the edge that ends that comparison.
- R4: The error of a comparison is the number of clock edges between the edge that samples the first rising pulse and the edge that samples the second. Rising pulses seen on the same edge give 0. Reference-first and feedback-first comparisons are measured the same way.
- R5: A PLL with its power-down bit set counts as locked in the combined output. When power-down is released, that PLL starts again unlocked with an empty run.
- R6: A PLL whose active bit is 0 is ignored, in both modes, whatever its pulses do.
- R7: In digital mode (analog_mode = 0), lock_det is the AND of the lock states of all included PLLs. A PLL is included when it is active and not powered down.
- R8: In analog mode (analog_mode = 1), lock_det is low while any included PLL is pumping, from the first edge of a comparison until its second edge. Otherwise lock_det is high.
- R9: Reset leaves every PLL unlocked, so lock_det reads 0 in digital mode when any PLL is included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | N_PLL | Reference divider output, one bit per PLL |
| fb_pulse | input | N_PLL | Feedback divider output, one bit per PLL |
| pll_active | input | N_PLL | 1 = the PLL takes part in the combined result |
| pll_powerdown | input | N_PLL | 1 = the PLL is powered down: its filter is cleared and it reports locked |
| analog_mode | input | 1 | 0 = filtered digital lock, 1 = pump-activity indication |
| lock_det | output | 1 | Combined lock-detect level |

## Verification
A per-PLL verdict changes on the same clock edge that samples the second rising pulse of a comparison. lock_det is decoded without a register from those verdicts, so a new lock state shows right after that edge. In analog mode, lock_det falls right after the edge that samples the first pulse and rises right after the edge that samples the second. The bench drives every pulse on a falling edge, so a gap of d falling edges between the two pulses gives an error of exactly d. It samples lock_det on the falling edge after the closing rising edge, and for analog mode on the falling edge while the pump is open.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

   // State of the per-PLL phase measurement
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,   // waiting for the first edge of a comparison
      PH_UP   = 2'd1,   // reference edge seen, waiting for feedback
      PH_DN   = 2'd2    // feedback edge seen, waiting for reference
   } ph_state_e;

endpackage

// File: rtl/lockdet_phase_meter.sv
module lockdet_phase_meter
   import pll_lock_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ref_i,
   input  logic             fb_i,
   output logic             pump_o,
   output logic             done_o,
   output logic [CNT_W-1:0] err_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   ph_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ref_q, fb_q;
   logic             ref_rise, fb_rise;

   assign ref_rise = ref_i & ~ref_q;
   assign fb_rise  = fb_i  & ~fb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PH_IDLE;
         cnt_q <= '0;
         ref_q <= 1'b0;
         fb_q  <= 1'b0;
      end else begin
         ref_q <= ref_i;
         fb_q  <= fb_i;
         if (clr) begin
            st_q  <= PH_IDLE;
            cnt_q <= '0;
         end else begin
            unique case (st_q)
               PH_IDLE: begin
                  if (ref_rise && !fb_rise) begin
                     st_q  <= PH_UP;
                     cnt_q <= CNT_ONE;
                  end else if (fb_rise && !ref_rise) begin
                     st_q  <= PH_DN;
                     cnt_q <= CNT_ONE;
                  end
               end
               PH_UP: begin
                  if (fb_rise) begin
                     st_q  <= PH_IDLE;
                     cnt_q <= '0;
                  end else if (cnt_q != CNT_MAX) begin
                     cnt_q <= cnt_q + CNT_ONE;
                  end
               end
               PH_DN: begin
                  if (ref_rise) begin
                     st_q  <= PH_IDLE;
                     cnt_q <= '0;
                  end else if (cnt_q != CNT_MAX) begin
                     cnt_q <= cnt_q + CNT_ONE;
                  end
               end
               default: begin
                  st_q  <= PH_IDLE;
                  cnt_q <= '0;
               end
            endcase
         end
      end
   end

   always_comb begin
      done_o = 1'b0;
      if (!clr) begin
         unique case (st_q)
            PH_IDLE: done_o = ref_rise & fb_rise;
            PH_UP:   done_o = fb_rise;
            PH_DN:   done_o = ref_rise;
            default: done_o = 1'b0;
         endcase
      end
   end

   assign pump_o = (st_q != PH_IDLE);
   assign err_o  = (st_q == PH_IDLE) ? '0 : cnt_q;

endmodule

// File: rtl/lockdet_hyst_filter.sv
module lockdet_hyst_filter #(
   parameter int CNT_W       = 4,
   parameter int ENTRY_TH    = 4,
   parameter int EXIT_TH     = 8,
   parameter int LOCK_CYCLES = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             done_i,
   input  logic [CNT_W-1:0] err_i,
   output logic             locked_o
);

   localparam int               GOOD_W  = $clog2(LOCK_CYCLES + 1);
   localparam logic [CNT_W-1:0] ENTRY_V = CNT_W'(ENTRY_TH);
   localparam logic [CNT_W-1:0] EXIT_V  = CNT_W'(EXIT_TH);
   localparam logic [GOOD_W-1:0] LAST_V = GOOD_W'(LOCK_CYCLES - 1);
   localparam logic [GOOD_W-1:0] ONE_V  = GOOD_W'(1);

   logic              locked_q;
   logic [GOOD_W-1:0] good_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         good_q   <= '0;
      end else if (clr) begin
         locked_q <= 1'b0;
         good_q   <= '0;
      end else if (done_i) begin
         if (!locked_q) begin
            if (err_i < ENTRY_V) begin
               if (good_q == LAST_V) begin
                  locked_q <= 1'b1;
                  good_q   <= '0;
               end else begin
                  good_q <= good_q + ONE_V;
               end
            end else begin
               good_q <= '0;
            end
         end else if (err_i > EXIT_V) begin
            locked_q <= 1'b0;
         end
      end
   end

   assign locked_o = locked_q;

endmodule

// File: rtl/pll_lock_filter.sv
module pll_lock_filter #(
   parameter int N_PLL       = 3,
   parameter int ENTRY_TH    = 4,
   parameter int EXIT_TH     = 8,
   parameter int LOCK_CYCLES = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_PLL-1:0] ref_pulse,
   input  logic [N_PLL-1:0] fb_pulse,
   input  logic [N_PLL-1:0] pll_active,
   input  logic [N_PLL-1:0] pll_powerdown,
   input  logic             analog_mode,
   output logic             lock_det
);

   // Saturated error must still read above the exit limit
   localparam int CNT_W = $clog2(EXIT_TH + 2);

   generate
      if (N_PLL < 1) begin : g_bad_n
         $error("N_PLL must be at least 1");
      end
      if (ENTRY_TH < 1) begin : g_bad_entry
         $error("ENTRY_TH must be at least 1");
      end
      if (EXIT_TH <= ENTRY_TH) begin : g_bad_exit
         $error("EXIT_TH must exceed ENTRY_TH");
      end
      if (LOCK_CYCLES < 1) begin : g_bad_cycles
         $error("LOCK_CYCLES must be at least 1");
      end
   endgenerate

   logic [N_PLL-1:0]       incl;
   logic [N_PLL-1:0]       pump;
   logic [N_PLL-1:0]       meas_done;
   logic [N_PLL-1:0]       pll_locked;
   logic [N_PLL*CNT_W-1:0] err_bus;

   assign incl = pll_active & ~pll_powerdown;

   generate
      for (genvar i = 0; i < N_PLL; i++) begin : g_pll
         lockdet_phase_meter #(
            .CNT_W (CNT_W)
         ) u_meter (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (pll_powerdown[i]),
            .ref_i  (ref_pulse[i]),
            .fb_i   (fb_pulse[i]),
            .pump_o (pump[i]),
            .done_o (meas_done[i]),
            .err_o  (err_bus[i*CNT_W +: CNT_W])
         );

         lockdet_hyst_filter #(
            .CNT_W       (CNT_W),
            .ENTRY_TH    (ENTRY_TH),
            .EXIT_TH     (EXIT_TH),
            .LOCK_CYCLES (LOCK_CYCLES)
         ) u_filter (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (pll_powerdown[i]),
            .done_i   (meas_done[i]),
            .err_i    (err_bus[i*CNT_W +: CNT_W]),
            .locked_o (pll_locked[i])
         );
      end
   endgenerate

   assign lock_det = analog_mode ? ~|(pump & incl) : &(pll_locked | ~incl);

endmodule

// File: rtl/pll_lock_filter_chk.sv
module pll_lock_filter_chk #(
   parameter int N_PLL    = 3,
   parameter int CNT_W    = 4,
   parameter int ENTRY_TH = 4,
   parameter int EXIT_TH  = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [N_PLL-1:0]       pll_active,
   input logic [N_PLL-1:0]       pll_powerdown,
   input logic                   analog_mode,
   input logic [N_PLL-1:0]       pump,
   input logic [N_PLL-1:0]       meas_done,
   input logic [N_PLL-1:0]       pll_locked,
   input logic [N_PLL*CNT_W-1:0] err_bus,
   input logic                   lock_det
);

   localparam logic [CNT_W-1:0] ENTRY_V = CNT_W'(ENTRY_TH);
   localparam logic [CNT_W-1:0] EXIT_V  = CNT_W'(EXIT_TH);

   generate
      for (genvar i = 0; i < N_PLL; i++) begin : g_chk
         AST_LOCK_FROM_GOOD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pll_locked[i]) |-> $past(meas_done[i] && !pll_powerdown[i] && (err_bus[i*CNT_W +: CNT_W] < ENTRY_V))); // R1

         AST_DROP_ON_WIDE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
            (pll_locked[i] && meas_done[i] && !pll_powerdown[i] && (err_bus[i*CNT_W +: CNT_W] > EXIT_V)) |=> !pll_locked[i]); // R3

         AST_POWERDOWN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
            pll_powerdown[i] |=> !pll_locked[i]); // R5
      end
   endgenerate

   AST_ANALOG_PUMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (analog_mode && |(pump & pll_active & ~pll_powerdown)) |-> !lock_det); // R8

   AST_NONE_INCLUDED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!analog_mode && &(~pll_active | pll_powerdown)) |-> lock_det); // R6

   AST_DIGITAL_AND: assert property (@(posedge clk) disable iff (!rst_n)
      (!analog_mode && lock_det) |-> &(pll_locked | ~pll_active | pll_powerdown)); // R7

endmodule

bind pll_lock_filter pll_lock_filter_chk #(
   .N_PLL    (N_PLL),
   .CNT_W    (CNT_W),
   .ENTRY_TH (ENTRY_TH),
   .EXIT_TH  (EXIT_TH)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pll_active    (pll_active),
   .pll_powerdown (pll_powerdown),
   .analog_mode   (analog_mode),
   .pump          (pump),
   .meas_done     (meas_done),
   .pll_locked    (pll_locked),
   .err_bus       (err_bus),
   .lock_det      (lock_det)
);

// File: tb/pll_lock_filter_test.sv
`timescale 1ns/1ps
module pll_lock_filter_test;

   localparam int N = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] ref_p = '0;
   logic [N-1:0] fb_p = '0;
   logic [N-1:0] active = 3'b001;
   logic [N-1:0] pdown = '0;
   logic         amode = 1'b0;
   logic         lock_det;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   pll_lock_filter #(
      .N_PLL(N), .ENTRY_TH(4), .EXIT_TH(8), .LOCK_CYCLES(5)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ref_pulse     (ref_p),
      .fb_pulse      (fb_p),
      .pll_active    (active),
      .pll_powerdown (pdown),
      .analog_mode   (amode),
      .lock_det      (lock_det)
   );

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: lock_det=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // One comparison on PLL idx: error of d samples, feedback leads if fb_first
   task automatic compare(int idx, bit fb_first, int d);
      @(negedge clk);
      if (d == 0) begin
         ref_p[idx] = 1'b1;
         fb_p[idx]  = 1'b1;
      end else begin
         if (fb_first) fb_p[idx] = 1'b1; else ref_p[idx] = 1'b1;
         repeat (d) @(negedge clk);
         if (fb_first) ref_p[idx] = 1'b1; else fb_p[idx] = 1'b1;
      end
      @(negedge clk);
      ref_p[idx] = 1'b0;
      fb_p[idx]  = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset unlocked", lock_det, 1'b0);
   endtask

   task automatic t_entry();
      for (int k = 0; k < 4; k++) compare(0, 1'b0, 3);
      check("R1 four good cycles not enough", lock_det, 1'b0);
      compare(0, 1'b0, 0);
      check("R1 fifth good cycle locks (R4 zero error)", lock_det, 1'b1);
   endtask

   task automatic t_exit();
      compare(0, 1'b0, 8);
      check("R3 error at exit limit keeps lock", lock_det, 1'b1);
      compare(0, 1'b0, 6);
      check("R3 error between limits keeps lock", lock_det, 1'b1);
      compare(0, 1'b0, 9);
      check("R3 error above exit limit drops lock", lock_det, 1'b0);
   endtask

   task automatic t_run_reset();
      for (int k = 0; k < 4; k++) compare(0, 1'b0, 2);
      compare(0, 1'b0, 4);
      check("R2 error at entry limit is bad (R4)", lock_det, 1'b0);
      for (int k = 0; k < 4; k++) compare(0, 1'b0, 2);
      check("R2 run restarted after bad cycle", lock_det, 1'b0);
      compare(0, 1'b0, 1);
      check("R2 fifth good after restart locks", lock_det, 1'b1);
   endtask

   task automatic t_fb_first();
      compare(0, 1'b1, 9);
      check("R4 feedback-first wide error drops lock", lock_det, 1'b0);
      for (int k = 0; k < 5; k++) compare(0, 1'b1, 3);
      check("R4 feedback-first good cycles lock", lock_det, 1'b1);
   endtask

   task automatic t_powerdown();
      @(negedge clk);
      active = 3'b011;
      @(negedge clk);
      check("R7 unlocked PLL1 pulls output low", lock_det, 1'b0);
      pdown[1] = 1'b1;
      repeat (2) @(negedge clk);
      check("R5 powered-down PLL reports locked", lock_det, 1'b1);
      for (int k = 0; k < 5; k++) compare(1, 1'b0, 1);
      pdown[1] = 1'b0;
      repeat (2) @(negedge clk);
      check("R5 pulses during power-down ignored, restart unlocked", lock_det, 1'b0);
      for (int k = 0; k < 5; k++) compare(1, 1'b0, 1);
      check("R7 both PLLs locked gives high", lock_det, 1'b1);
      pdown[0] = 1'b1;
      repeat (2) @(negedge clk);
      pdown[0] = 1'b0;
      repeat (2) @(negedge clk);
      check("R5 PLL0 restarts unlocked after power-down", lock_det, 1'b0);
      for (int k = 0; k < 5; k++) compare(0, 1'b0, 0);
      check("R7 PLL0 relocked", lock_det, 1'b1);
   endtask

   task automatic t_inactive();
      compare(2, 1'b0, 20);
      check("R6 inactive PLL2 with wide error ignored", lock_det, 1'b1);
   endtask

   task automatic t_analog();
      @(negedge clk);
      amode = 1'b1;
      @(negedge clk);
      check("R8 no pumping gives high", lock_det, 1'b1);
      ref_p[1] = 1'b1;
      @(negedge clk);
      check("R8 PLL1 pumping up gives low", lock_det, 1'b0);
      fb_p[1] = 1'b1;
      @(negedge clk);
      check("R8 pump closed gives high", lock_det, 1'b1);
      ref_p[1] = 1'b0;
      fb_p[1] = 1'b0;
      @(negedge clk);
      fb_p[0] = 1'b1;
      @(negedge clk);
      check("R8 PLL0 pumping down gives low", lock_det, 1'b0);
      ref_p[0] = 1'b1;
      @(negedge clk);
      check("R8 PLL0 pump closed gives high", lock_det, 1'b1);
      ref_p[0] = 1'b0;
      fb_p[0] = 1'b0;
      @(negedge clk);
      ref_p[2] = 1'b1;
      repeat (2) @(negedge clk);
      check("R6 inactive PLL2 pumping ignored in analog mode", lock_det, 1'b1);
      fb_p[2] = 1'b1;
      @(negedge clk);
      ref_p[2] = 1'b0;
      fb_p[2] = 1'b0;
      amode = 1'b0;
      @(negedge clk);
      check("R7 digital mode restored, both locked", lock_det, 1'b1);
   endtask

   initial begin
      t_reset();
      t_entry();
      t_exit();
      t_run_reset();
      t_fb_first();
      t_powerdown();
      t_inactive();
      t_analog();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule